// File: doc/BRIEF.md
# Negacyclic Schoolbook Polynomial Multiplier

This block multiplies two polynomials of N coefficients each. Coefficients are reduced modulo a prime P, and the product is folded modulo x^N + 1. When a term's degree reaches N or more, it comes back at degree k − N with its sign inverted. The block uses the quadratic method: it makes one modular multiply-accumulate step per clock cycle and needs N² steps for the whole product.

The host starts a job with a start pulse while the block is idle. It then streams the N coefficients of the first operand, followed by the N coefficients of the second, each on a cycle with the load strobe high. After the last coefficient the block runs by itself. Each result coefficient is finished during the last outer pass, and the block presents it on the result port straight away in ascending order rather than writing it back. A one-cycle completion pulse follows the last result.

Top module: `negacyclic_mul`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy`, `done` and `res_valid` are all 0.
- R2: A `start` pulse sampled while `busy` is 0 makes `busy` read 1 from the next cycle, and the block then accepts coefficients.
- R3: A `start` sampled while `busy` is 1 has no effect. The current job's results, their count and their timing are unchanged.
- R4: The first N cycles with `ld_valid` high after a start load operand a, coefficient index 0 upward. The next N such cycles load operand b the same way. Cycles with `ld_valid` low are skipped and do not advance the index.
- R5: `ld_valid` outside the loading phase, including during the multiply, changes nothing in the result.
- R6: Result coefficient k equals the sum of a_i·b_j over i+j = k, minus the sum of a_i·b_j over i+j = k+N, reduced to [0, P−1].
- R7: Each job gives exactly N cycles with `res_valid` high, carrying coefficients 0 to N−1 in ascending order, each value below P.
- R8: With loading unbroken, counting clock edges after the edge that samples `start`, the first result is valid after edge 2N + N² − N + 1 and the last after edge 2N + N².
- R9: `done` is high for exactly one cycle, the cycle right after the last result. In that cycle `busy` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (accepted only while idle) |
| ld_valid | input | 1 | Coefficient on `ld_data` is valid |
| ld_data | input | W | Coefficient to load, in [0, P−1] |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | `res_data` holds a result coefficient |
| res_data | output | W | Result coefficient, ascending index |

## Verification
The multiplier is exercised with several operand pairs, each of which separates a different kind of fault:
- A zero operand exposes a result memory that is not cleared between jobs.
- A constant-one operand shows whether the partial products land at the right indices without any wrap.
- The single monomial x shows whether the one wrapped coefficient comes back negated and not plainly rotated.
- All-(P−1) operands and two top-degree monomials push the modular add, the subtract and the wrap boundary to their limits.
- Random operands cover general mixing.

One job pauses the load strobe to confirm that index advance depends only on the strobe. Another job injects `start` and load beats during the multiply to show that neither disturbs the values or the timing.

// File: rtl/negacyclic_mul.sv
module negacyclic_mul #(
  parameter int N = 16,
  parameter int W = 17,
  parameter int unsigned P = 65537
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         ld_valid,
  input  logic [W-1:0] ld_data,
  output logic         busy,
  output logic         done,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  localparam int AW = $clog2(N);
  localparam logic [W:0] PX = (W+1)'(P);
  localparam logic [2*W-1:0] PW = (2*W)'(P);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} st_t;
  st_t st;

  logic [W-1:0] mem_a [N];
  logic [W-1:0] mem_b [N];
  logic [W-1:0] mem_r [N];

  logic [AW:0]   lcnt;
  logic [AW-1:0] oi, ok;

  wire [AW-1:0]  jj   = ok - oi;
  wire           wrap = ok < oi;
  wire           last = oi == AW'(N-1);

  wire [2*W-1:0] full = {{W{1'b0}}, mem_a[oi]} * {{W{1'b0}}, mem_b[jj]};
  wire [W-1:0]   prod = W'(full % PW);
  wire [W-1:0]   racc = (oi == '0) ? '0 : mem_r[ok];
  wire [W:0]     sum  = {1'b0, racc} + {1'b0, prod};
  wire [W:0]     dif  = {1'b0, racc} + PX - {1'b0, prod};
  wire [W:0]     sred = (sum >= PX) ? sum - PX : sum;
  wire [W:0]     dred = (dif >= PX) ? dif - PX : dif;
  wire [W-1:0]   nxt  = W'(wrap ? dred : sred);

  assign busy = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lcnt      <= '0;
      oi        <= '0;
      ok        <= '0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      done      <= 1'b0;
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_LOAD;
          lcnt <= '0;
        end
        S_LOAD: if (ld_valid) begin
          lcnt <= lcnt + 1'b1;
          if (lcnt == (AW+1)'(2*N-1)) begin
            st <= S_RUN;
            oi <= '0;
            ok <= '0;
          end
        end
        S_RUN: begin
          if (last) begin
            res_valid <= 1'b1;
            res_data  <= nxt;
          end
          ok <= ok + 1'b1;
          if (ok == AW'(N-1)) begin
            oi <= oi + 1'b1;
            if (last) st <= S_FIN;
          end
        end
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_LOAD && ld_valid) begin
      if (lcnt[AW]) mem_b[lcnt[AW-1:0]] <= ld_data;
      else          mem_a[lcnt[AW-1:0]] <= ld_data;
    end
    if (st == S_RUN && !last) mem_r[ok] <= nxt;
  end
endmodule

// File: rtl/negacyclic_mul_chk.sv
module negacyclic_mul_chk #(
  parameter int W = 17,
  parameter int unsigned P = 65537
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         res_valid,
  input logic [W-1:0] res_data
);
  a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ({1'b0, res_data} < (W+1)'(P)));
  a_r7_valid_in_job: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind negacyclic_mul negacyclic_mul_chk #(.W(W), .P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/negacyclic_mul_bench.sv
`timescale 1ns/1ps
module negacyclic_mul_bench;
  localparam int N = 16;
  localparam int W = 17;
  localparam int unsigned P = 65537;
  localparam int NJOB = 7;
  // {kind[3:0], seed[7:0], gap, poke, 2'b0}
  localparam logic [15:0] VEC [NJOB] = '{
    {4'd0, 8'd11, 1'b0, 1'b0, 2'b0},
    {4'd1, 8'd23, 1'b0, 1'b0, 2'b0},
    {4'd2, 8'd37, 1'b0, 1'b0, 2'b0},
    {4'd3, 8'd00, 1'b0, 1'b0, 2'b0},
    {4'd5, 8'd00, 1'b0, 1'b0, 2'b0},
    {4'd4, 8'd59, 1'b1, 1'b0, 2'b0},
    {4'd4, 8'd71, 1'b0, 1'b1, 2'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, ld_valid = 0;
  logic [W-1:0] ld_data = '0;
  logic busy, done, res_valid;
  logic [W-1:0] res_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  negacyclic_mul #(.N(N), .W(W), .P(P)) u_negacyclic_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid), .ld_data(ld_data),
    .busy(busy), .done(done), .res_valid(res_valid), .res_data(res_data));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint coef(input int kind, input int which, input int idx, input int seed);
    longint unsigned h;
    case (kind)
      0: if (which == 0) return 0;
      1: if (which == 0) return (idx == 0) ? 1 : 0;
      2: if (which == 0) return (idx == 1) ? 1 : 0;
      3: return P - 1;
      5: return (idx == N-1) ? 1 : 0;
      default: ;
    endcase
    h = longint'(seed) * 1103515245 + longint'(idx) * 12345 + longint'(which) * 7919 + 17;
    h = h ^ (h >> 13);
    return longint'(h % P);
  endfunction

  task automatic run_job(input logic [15:0] v);
    int kind = v[15:12], seed = v[11:4];
    bit gap = v[3], poke = v[2];
    longint ea [N], eb [N], ex [N], got [N];
    int t, nout = 0, first_t = -1, last_t = -1, done_t = -1;
    for (int i = 0; i < N; i++) begin
      ea[i] = coef(kind, 0, i, seed);
      eb[i] = coef(kind, 1, i, seed);
      ex[i] = 0;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        longint term = (ea[i] * eb[j]) % P;
        if (i + j >= N) ex[(i+j)%N] = (ex[(i+j)%N] + P - term) % P;
        else            ex[i+j]     = (ex[i+j] + term) % P;
      end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    for (int k = 0; k < 2*N; k++) begin
      if (gap && k == 3) begin ld_valid = 0; @(negedge clk); end
      ld_valid = 1;
      ld_data = W'(k < N ? ea[k] : eb[k-N]);
      @(negedge clk);
    end
    ld_valid = 0;
    t = 2*N;
    while (t < 2*N + N*N + 20) begin
      @(negedge clk); t++;
      if (poke && (t == 2*N + 5 || t == 2*N + N*(N-1) + 3)) begin
        start = 1; ld_valid = 1; ld_data = W'(123);
      end else begin
        start = 0; ld_valid = 0;
      end
      if (res_valid) begin
        if (nout < N) got[nout] = res_data;
        if (nout == 0) first_t = t;
        last_t = t;
        nout++;
      end
      if (done) begin
        done_t = t;
        chk(busy === 1'b0, "R9 busy low at done", busy, 0);
        break;
      end
    end
    start = 0; ld_valid = 0;
    chk(nout == N, "R7 result count", nout, N);
    if (nout == N)
      for (int k = 0; k < N; k++)
        chk(got[k] == ex[k], $sformatf("R6 coefficient %0d", k), got[k], ex[k]);
    chk(done_t == last_t + 1, "R9 done follows last result", done_t, last_t + 1);
    if (!gap) begin
      chk(first_t == 2*N + N*N - N + 1, "R8 first result edge", first_t, 2*N + N*N - N + 1);
      chk(last_t == 2*N + N*N, "R8 last result edge", last_t, 2*N + N*N);
    end
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && res_valid === 1'b0, "R1 outputs in reset",
        {busy, done, res_valid}, 0);
    rst_n = 1;
    ld_valid = 1; ld_data = W'(5);
    @(negedge clk);
    ld_valid = 0;
    chk(busy === 1'b0 && done === 1'b0 && res_valid === 1'b0, "R1 outputs after reset",
        {busy, done, res_valid}, 0);
    // R3 R4 R5 covered by gap and poke jobs in the table
    for (int r = 0; r < NJOB; r++) run_job(VEC[r]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule